// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer

This peripheral holds a parameterized number of independent down-counters behind a simple register bus with write strobe, read strobe, address and data lines. Each counter is configured through a control word and counts down either from an immediate start value or from a separately held reload value. Software measures elapsed time by subtracting the value it reads back from the value it loaded. It takes a periodic interrupt from a counter that reloads itself each time it reaches zero.

Every counter can run in periodic mode or in free-running mode, with a 16-bit or a 32-bit count, behind a prescaler that divides the clock by 1, 16 or 256. The reload value is held in its own register. Software can therefore change the next period without disturbing the count in progress. The counters share a mask register, a raw status view, a masked status view and a write-one-to-clear register. Together these feed a single interrupt line.

Top module: `dtu_timer_unit`

## Requirements
- R1: After reset, every register reads zero, no counter runs and `irq_o` is low.
- R2: A write to a counter's start-value register (offset 0x0) sets the current count and also the reload register (offset 0xC). A write to the reload register alone leaves the current count unchanged.
- R3: A counter changes only while its run bit (control bit 7) is set, by one per prescaler tick. The first tick at divide-by-one lands on the clock edge after the write that sets the run bit. A control write with bit 7 clear freezes the count.
- R4: In periodic mode (control bit 6 set), the tick that brings the count from 1 to 0 sets the counter's raw flag. The next tick loads the count from the reload register.
- R5: In free-running mode (control bit 6 clear), the tick that brings the count to 0 sets the raw flag. The next tick wraps the count to 0xFFFF (16-bit) or 0xFFFFFFFF (32-bit).
- R6: With control bit 1 clear, the counter is 16 bits wide. Only the low 16 bits count and the value register's upper 16 bits read zero. With bit 1 set, all 32 bits count.
- R7: Control bits [3:2] select the prescaler: 00 divides by 1, 01 by 16, and 10 or 11 by 256. With divide-by-D, the n-th decrement lands on the edge D·n cycles after the enabling write.
- R8: The mask register (0xF0, bit n for counter n) gates each raw flag. The masked status (0xF8) reads raw AND mask, and `irq_o` is the OR of that masked status.
- R9: A write to the clear register (0xFC) clears the raw flags (0xF4) whose data bit is 1 and leaves the others unchanged. A flag being set in the same cycle as its clear stays set.
- R10: Counter n occupies addresses n·0x10 + {0x0 start value, 0x4 current value (read-only), 0x8 control, 0xC reload value}. The shared registers sit at 0xF0 mask, 0xF4 raw, 0xF8 masked and 0xFC clear (reads zero).
- R11: Read data is registered: `bus_rdata` takes the addressed value on the clock edge where `bus_re` is high and holds otherwise. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
The assertions assume that only one register is written per cycle and that the bus never asks for a write and a read that interfere. They also assume that software does not change the control word while it relies on the reload check. The bench drives only single-cycle strobes with one address at a time. It stops counters, loads them and clears their flags before setting the run bit. Its expected values come from a tick-count model, keyed to the edge on which each enabling write and each read lands.

// File: rtl/dtu_pkg.sv
// Shared constants, control-word layout and helpers for the timer unit.
// Assumes a 32-bit data bus and an 8-bit byte address.
package dtu_pkg;

    localparam int DATA_W = 32;
    localparam int HALF_W = 16;

    // Control-word bit positions
    localparam int CTL_RUN_BIT  = 7;
    localparam int CTL_PER_BIT  = 6;
    localparam int CTL_PS_HI    = 3;
    localparam int CTL_PS_LO    = 2;
    localparam int CTL_WIDE_BIT = 1;

    // Per-counter register offsets (low address nibble)
    localparam logic [3:0] OFS_START = 4'h0;
    localparam logic [3:0] OFS_VALUE = 4'h4;
    localparam logic [3:0] OFS_CTRL  = 4'h8;
    localparam logic [3:0] OFS_RELD  = 4'hC;

    // Shared page and offsets within it
    localparam logic [3:0] SHARED_PAGE = 4'hF;
    localparam logic [3:0] SH_MASK = 4'h0;
    localparam logic [3:0] SH_RAW  = 4'h4;
    localparam logic [3:0] SH_MIS  = 4'h8;
    localparam logic [3:0] SH_CLR  = 4'hC;

    typedef enum logic [1:0] {
        PS_DIV1   = 2'b00,
        PS_DIV16  = 2'b01,
        PS_DIV256 = 2'b10,
        PS_DIV256_ALT = 2'b11
    } ps_e;

    typedef struct packed {
        logic run;
        logic periodic;
        ps_e  ps;
        logic wide;
    } ctl_t;

    // Extract the control fields from the low byte of a bus write.
    function automatic ctl_t ctl_unpack(input logic [7:0] w);
        ctl_t c;
        c.run      = w[CTL_RUN_BIT];
        c.periodic = w[CTL_PER_BIT];
        c.ps       = ps_e'(w[CTL_PS_HI:CTL_PS_LO]);
        c.wide     = w[CTL_WIDE_BIT];
        return c;
    endfunction

    // Rebuild the bus view of the control word.
    function automatic logic [DATA_W-1:0] ctl_pack(input ctl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CTL_RUN_BIT]           = c.run;
        w[CTL_PER_BIT]           = c.periodic;
        w[CTL_PS_HI:CTL_PS_LO]   = c.ps;
        w[CTL_WIDE_BIT]          = c.wide;
        return w;
    endfunction

endpackage

// File: rtl/dtu_prescaler.sv
// Clock divider for one counter. While run is high it advances a free
// counter and issues a tick once every 1, 16 or 256 cycles, picked by sel.
// Assumes: the counter restarts from zero whenever run is low, so the first
// tick is a whole division after enabling.
module dtu_prescaler
    import dtu_pkg::*;
#(
    parameter int MID_LOG = 4,
    parameter int TOP_LOG = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  ps_e  sel,
    output logic tick_o
);

    logic [TOP_LOG-1:0] pre_q;

    // Advance the divider while running, hold it at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      pre_q <= '0;
        else if (run)    pre_q <= pre_q + 1'b1;
        else             pre_q <= '0;
    end

    // Decode the tick for the selected division.
    always_comb begin
        unique case (sel)
            PS_DIV1:  tick_o = run;
            PS_DIV16: tick_o = run && (pre_q[MID_LOG-1:0] == '1);
            default:  tick_o = run && (pre_q == '1);
        endcase
    end

    // A stopped divider restarts from zero.
    assert_idle_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pre_q == '0));

endmodule

// File: rtl/dtu_counter.sv
// One down-counter with its control, start-value and reload registers.
// Counts down on prescaler ticks. At zero it reloads (periodic) or wraps to
// all ones (free-running). expire_o pulses on the tick that reaches zero.
// Assumes: at most one of ld_we, rl_we, ctl_we is high in a cycle.
module dtu_counter
    import dtu_pkg::*;
#(
    parameter int CW = DATA_W,
    parameter int HW = HALF_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_we,
    input  logic          rl_we,
    input  logic          ctl_we,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] start_o,
    output logic [CW-1:0] reload_o,
    output logic [CW-1:0] ctl_o,
    output logic [CW-1:0] val_o,
    output logic          expire_o
);

    localparam logic [CW-1:0] ONE       = CW'(1);
    localparam logic [CW-1:0] TOP_WIDE  = '1;
    localparam logic [CW-1:0] TOP_NARW  = {{(CW-HW){1'b0}}, {HW{1'b1}}};

    ctl_t          ctl_q;
    logic [CW-1:0] start_q;
    logic [CW-1:0] reld_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] eff;
    logic [CW-1:0] reload_val;
    logic          tick;

    dtu_prescaler u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (ctl_q.run),
        .sel    (ctl_q.ps),
        .tick_o (tick)
    );

    // Hold the control fields written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (ctl_we) ctl_q <= ctl_unpack(wdata[7:0]);
    end

    // Keep the start value as written, for readback.
    always_ff @(posedge clk) begin
        if (!rst_n)     start_q <= '0;
        else if (ld_we) start_q <= wdata;
    end

    // The reload value follows both the start-value and reload writes.
    always_ff @(posedge clk) begin
        if (!rst_n)              reld_q <= '0;
        else if (ld_we || rl_we) reld_q <= wdata;
    end

    // Narrow mode sees only the low half of the stored count.
    always_comb begin
        eff        = ctl_q.wide ? cnt_q  : {{(CW-HW){1'b0}}, cnt_q[HW-1:0]};
        reload_val = ctl_q.wide ? reld_q : {{(CW-HW){1'b0}}, reld_q[HW-1:0]};
    end

    // Count down, reload or wrap at zero, or take a direct load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (ld_we) begin
            cnt_q <= wdata;
        end else if (tick) begin
            if (eff == '0)
                cnt_q <= ctl_q.periodic ? reload_val
                                        : (ctl_q.wide ? TOP_WIDE : TOP_NARW);
            else
                cnt_q <= eff - ONE;
        end
    end

    assign expire_o = tick && !ld_we && (eff == ONE);
    assign start_o  = start_q;
    assign reload_o = reld_q;
    assign ctl_o    = ctl_pack(ctl_q);
    assign val_o    = eff;

    // A stopped counter only moves on a direct load.
    assert_hold_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q.run && !ld_we) |=> $stable(cnt_q));

    // A direct load shows up as the current value one cycle later.
    assert_load_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_we |=> (val_o == ($past(ctl_q.wide) ? $past(wdata)
                             : {{(CW-HW){1'b0}}, $past(wdata[HW-1:0])})));

    // Periodic expiry continues from the reload register.
    assert_periodic_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ctl_q.periodic && (val_o == '0) && !ld_we && !ctl_we)
        |=> (val_o == ($past(ctl_q.wide) ? $past(reld_q)
                       : {{(CW-HW){1'b0}}, $past(reld_q[HW-1:0])})));

    // Free-running expiry wraps to the all-ones value of the size.
    assert_free_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ctl_q.periodic && (val_o == '0) && !ld_we && !ctl_we)
        |=> (ctl_q.wide ? (val_o == '1) : (val_o == TOP_NARW)));

endmodule

// File: rtl/dtu_irq.sv
// Shared interrupt state: a mask register and sticky raw flags with
// write-one-to-clear. A new expiry wins over a clear in the same cycle.
// Assumes: mask_we and clr_we are never high together.
module dtu_irq #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mask_we,
    input  logic         clr_we,
    input  logic [N-1:0] wdata,
    input  logic [N-1:0] expire,
    output logic [N-1:0] mask_o,
    output logic [N-1:0] raw_o,
    output logic         irq_o
);

    logic [N-1:0] mask_q;
    logic [N-1:0] raw_q;
    logic [N-1:0] clr_bits;

    assign clr_bits = clr_we ? wdata : '0;

    // Hold the interrupt enables.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= wdata;
    end

    // Sticky raw flags: set by expiry, cleared by one bits.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= (raw_q & ~clr_bits) | expire;
    end

    assign mask_o = mask_q;
    assign raw_o  = raw_q;
    assign irq_o  = |(raw_q & mask_q);

    // An expiry always lands in the raw flags.
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|expire) |=> ((raw_o & $past(expire)) == $past(expire)));

    // A clear removes flags that were not re-set in the same cycle.
    assert_clear_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((raw_o & $past(wdata & ~expire)) == '0));

    // Without a clear, no flag drops.
    assert_flags_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((raw_o & $past(raw_o)) == $past(raw_o)));

    // The line stays quiet when no enabled flag is pending.
    assert_quiet_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw_o & mask_o) == '0) |-> !irq_o);

endmodule

// File: rtl/dtu_timer_unit.sv
// Top of the timer unit: address decode, per-counter instances, the shared
// interrupt block and a registered read port.
// Assumes: N_TMR is at most 15, so that the counter pages stay below the
// shared page, and single-cycle strobes.
module dtu_timer_unit
    import dtu_pkg::*;
#(
    parameter int N_TMR  = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);

    localparam int PG_LO = 4;
    localparam int PG_W  = ADDR_W - PG_LO;

    logic [PG_W-1:0]   page;
    logic [PG_LO-1:0]  ofs;
    logic              sh_hit;
    logic [N_TMR-1:0]  expire;
    logic [N_TMR-1:0]  mask_v;
    logic [N_TMR-1:0]  raw_v;
    logic [DATA_W-1:0] start_a  [N_TMR];
    logic [DATA_W-1:0] reload_a [N_TMR];
    logic [DATA_W-1:0] ctl_a    [N_TMR];
    logic [DATA_W-1:0] val_a    [N_TMR];
    logic [DATA_W-1:0] rmux;

    assign page   = bus_addr[ADDR_W-1:PG_LO];
    assign ofs    = bus_addr[PG_LO-1:0];
    assign sh_hit = (page == PG_W'(SHARED_PAGE));

    for (genvar gi = 0; gi < N_TMR; gi++) begin : g_cnt
        logic hit;
        assign hit = bus_we && (page == PG_W'(gi));
        dtu_counter u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .ld_we    (hit && (ofs == OFS_START)),
            .rl_we    (hit && (ofs == OFS_RELD)),
            .ctl_we   (hit && (ofs == OFS_CTRL)),
            .wdata    (bus_wdata),
            .start_o  (start_a[gi]),
            .reload_o (reload_a[gi]),
            .ctl_o    (ctl_a[gi]),
            .val_o    (val_a[gi]),
            .expire_o (expire[gi])
        );
    end

    dtu_irq #(.N(N_TMR)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_we (bus_we && sh_hit && (ofs == SH_MASK)),
        .clr_we  (bus_we && sh_hit && (ofs == SH_CLR)),
        .wdata   (bus_wdata[N_TMR-1:0]),
        .expire  (expire),
        .mask_o  (mask_v),
        .raw_o   (raw_v),
        .irq_o   (irq_o)
    );

    // Select the addressed register; unmapped addresses give zero.
    always_comb begin
        rmux = '0;
        if (sh_hit) begin
            unique case (ofs)
                SH_MASK: rmux = {{(DATA_W-N_TMR){1'b0}}, mask_v};
                SH_RAW:  rmux = {{(DATA_W-N_TMR){1'b0}}, raw_v};
                SH_MIS:  rmux = {{(DATA_W-N_TMR){1'b0}}, raw_v & mask_v};
                default: rmux = '0;
            endcase
        end else begin
            for (int i = 0; i < N_TMR; i++) begin
                if (page == PG_W'(i)) begin
                    unique case (ofs)
                        OFS_START: rmux = start_a[i];
                        OFS_VALUE: rmux = val_a[i];
                        OFS_CTRL:  rmux = ctl_a[i];
                        OFS_RELD:  rmux = reload_a[i];
                        default:   rmux = '0;
                    endcase
                end
            end
        end
    end

    // Capture read data on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_re) bus_rdata <= rmux;
    end

    // Read data holds between strobes.
    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> $stable(bus_rdata));

endmodule

// File: tb/dtu_timer_unit_test.sv
`timescale 1ns/1ps
module dtu_timer_unit_test;

    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        we, re;
    logic [7:0]  addr;
    logic [31:0] wdata;
    wire  [31:0] rdata;
    wire         irq;

    int unsigned cyc = 0;
    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dtu_timer_unit #(.N_TMR(N)) uut (
        .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_re(re),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Write lands on the returned edge index.
    task automatic wr(input logic [7:0] a, input logic [31:0] d, output int unsigned e);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d; e = cyc + 1;
        @(negedge clk);
        we = 1'b0;
    endtask

    // Returns the data seen after edge n and the interrupt line at that time.
    task automatic rd(input logic [7:0] a, output logic [31:0] d,
                      output int unsigned n, output logic irq_s);
        @(negedge clk);
        re = 1'b1; addr = a; n = cyc; irq_s = irq;
        @(negedge clk);
        re = 1'b0; d = rdata;
    endtask

    function automatic longint unsigned divisor(input logic [1:0] ps);
        return (ps == 2'b00) ? 1 : ((ps == 2'b01) ? 16 : 256);
    endfunction

    // Expected count after t ticks.
    function automatic logic [31:0] model_val(input logic [31:0] l0, input logic [31:0] b0,
                                              input logic per, input logic wide,
                                              input longint unsigned t);
        longint unsigned l, b, top, tp;
        l   = wide ? l0 : (l0 & 32'hFFFF);
        b   = wide ? b0 : (b0 & 32'hFFFF);
        top = wide ? 64'hFFFF_FFFF : 64'hFFFF;
        if (t <= l) return 32'(l - t);
        tp = t - l - 1;
        if (per) return 32'(b - (tp % (b + 1)));
        return 32'(top - (tp % (top + 1)));
    endfunction

    // Stop, load, clear and start one counter; returns the enabling edge.
    task automatic start_cnt(input int idx, input logic [31:0] l, input logic [31:0] b,
                             input logic [7:0] ctl, output int unsigned e);
        int unsigned x;
        logic [7:0] base;
        base = 8'(idx << 4);
        wr(base | 8'h8, 32'h0, x);
        wr(base | 8'h0, l, x);
        wr(base | 8'hC, b, x);
        wr(8'hFC, 32'(1 << idx), x);
        wr(base | 8'h8, {24'h0, ctl & 8'h7F}, x);
        wr(base | 8'h8, {24'h0, ctl | 8'h80}, e);
    endtask

    // Compare value and raw flag against the model over several reads.
    task automatic run_check(input string tag, input int idx, input logic [31:0] l,
                             input logic [31:0] b, input logic [7:0] ctl,
                             input int unsigned e, input int nrd, input int gap);
        logic [31:0] d;
        int unsigned n;
        logic        s;
        longint unsigned t, lm;
        lm = ctl[1] ? l : (l & 32'hFFFF);
        for (int k = 0; k < nrd; k++) begin
            repeat (gap) @(negedge clk);
            rd(8'(idx << 4) | 8'h4, d, n, s);
            t = (n - e) / divisor(ctl[3:2]);
            chk({tag, " value"}, d, model_val(l, b, ctl[6], ctl[1], t));
            rd(8'hF4, d, n, s);
            t = (n - e) / divisor(ctl[3:2]);
            chk({tag, " raw flag"}, {31'h0, d[idx]}, {31'h0, (t >= lm)});
        end
    endtask

    initial begin
        #(8ns * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] d, d2;
        int unsigned n, e, e2, x;
        logic s;
        void'($urandom(32'd1357));
        rst_n = 1'b0; we = 1'b0; re = 1'b0; addr = '0; wdata = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R10: everything reads zero after reset
        for (int i = 0; i < N; i++)
            for (int o = 0; o < 16; o += 4) begin
                rd(8'((i << 4) | o), d, n, s);
                chk("R1 R10 reset counter reg", d, 32'h0);
            end
        for (int o = 0; o < 16; o += 4) begin
            rd(8'(8'hF0 | o), d, n, s);
            chk("R1 R10 reset shared reg", d, 32'h0);
        end
        chk("R1 reset irq", {31'h0, irq}, 32'h0);

        // R2 / R6: direct load in narrow mode
        wr(8'h00, 32'h1234_5678, x);
        rd(8'h04, d, n, s); chk("R6 narrow value", d, 32'h0000_5678);
        rd(8'h00, d, n, s); chk("R2 start readback", d, 32'h1234_5678);
        rd(8'h0C, d, n, s); chk("R2 reload follows load", d, 32'h1234_5678);
        wr(8'h08, 32'h02, x);
        rd(8'h04, d, n, s); chk("R6 wide value", d, 32'h1234_5678);
        rd(8'h08, d, n, s); chk("R10 control readback", d, 32'h02);
        wr(8'h0C, 32'h0000_AAAA, x);
        rd(8'h04, d, n, s); chk("R2 reload write keeps count", d, 32'h1234_5678);
        rd(8'h0C, d, n, s); chk("R2 reload readback", d, 32'h0000_AAAA);
        rd(8'h00, d, n, s); chk("R2 start untouched", d, 32'h1234_5678);

        // R3: no movement while stopped
        repeat (30) @(negedge clk);
        rd(8'h04, d, n, s); chk("R3 stopped holds", d, 32'h1234_5678);

        // R4 / R3: periodic, wide, divide by 1
        start_cnt(0, 32'd10, 32'd4, 8'h42, e);
        run_check("R4 periodic", 0, 32'd10, 32'd4, 8'h42, e, 12, 1);

        // R3: stopping freezes the count after the last tick at the stop edge
        wr(8'h08, 32'h42, e2);
        rd(8'h04, d, n, s);
        chk("R3 frozen at stop", d, model_val(32'd10, 32'd4, 1'b1, 1'b1, e2 - e));
        repeat (20) @(negedge clk);
        rd(8'h04, d2, n, s); chk("R3 stays frozen", d2, d);

        // R5 / R6: free-running narrow wraps to 0xFFFF
        start_cnt(1, 32'h0003_0005, 32'd9, 8'h80, e);
        run_check("R5 R6 free narrow", 1, 32'h0003_0005, 32'd9, 8'h80, e, 6, 0);
        rd(8'h14, d, n, s);
        chk("R6 upper half zero", {16'h0, d[31:16]}, 32'h0);
        // R5: free-running wide wraps to all ones
        start_cnt(2, 32'd3, 32'd9, 8'h82, e);
        run_check("R5 free wide", 2, 32'd3, 32'd9, 8'h82, e, 4, 1);

        // R7: divide by 16
        start_cnt(3, 32'd100, 32'd5, 8'h46, e);
        run_check("R7 div16", 3, 32'd100, 32'd5, 8'h46, e, 12, 3);
        // R7: divide by 256 across the first boundary
        start_cnt(3, 32'd3, 32'd2, 8'h4A, e);
        while (cyc < e + 246) @(negedge clk);
        run_check("R7 div256", 3, 32'd3, 32'd2, 8'h4A, e, 5, 0);
        // R7: code 11 also divides by 256
        start_cnt(3, 32'd50, 32'd2, 8'h4E, e);
        repeat (300) @(negedge clk);
        run_check("R7 div256 alt", 3, 32'd50, 32'd2, 8'h4E, e, 1, 0);

        // R8: masking of a pending flag
        for (int i = 0; i < N; i++) wr(8'((i << 4) | 8), 32'h0, x);
        wr(8'hFC, 32'hF, x);
        rd(8'hF4, d, n, s); chk("R9 all cleared", d, 32'h0);
        start_cnt(0, 32'd2, 32'd1000, 8'h42, e);
        repeat (5) @(negedge clk);
        wr(8'h08, 32'h0, x);
        rd(8'hF4, d, n, s); chk("R4 raw set on expiry", d, 32'h1);
        chk("R8 irq low when masked", {31'h0, s}, 32'h0);
        rd(8'hF8, d, n, s); chk("R8 masked status off", d, 32'h0);
        wr(8'hF0, 32'h1, x);
        rd(8'hF8, d, n, s); chk("R8 masked status on", d, 32'h1);
        chk("R8 irq high", {31'h0, s}, 32'h1);
        wr(8'hF0, 32'hE, x);
        rd(8'hF8, d, n, s); chk("R8 other bits mask nothing", d, 32'h0);
        chk("R8 irq low again", {31'h0, s}, 32'h0);

        // R9: write-one-to-clear
        wr(8'hF0, 32'h1, x);
        wr(8'hFC, 32'hE, x);
        rd(8'hF4, d, n, s); chk("R9 zero bit keeps flag", d, 32'h1);
        wr(8'hFC, 32'h1, x);
        rd(8'hF4, d, n, s); chk("R9 one bit clears flag", d, 32'h0);
        chk("R9 irq drops after clear", {31'h0, s}, 32'h0);
        // R9: clear landing on the expiry edge loses
        start_cnt(0, 32'd20, 32'd1000, 8'h42, e);
        while (cyc < e + 18) @(negedge clk);
        wr(8'hFC, 32'h1, e2);
        chk("R9 clear on expiry edge", e2, e + 20);
        rd(8'hF4, d, n, s); chk("R9 set wins over clear", d, 32'h1);
        wr(8'hFC, 32'h1, x);
        rd(8'hF4, d, n, s); chk("R9 later clear works", d, 32'h0);
        wr(8'h08, 32'h0, x);
        wr(8'hF0, 32'h0, x);

        // R11: unmapped reads and hold
        rd(8'h01, d, n, s); chk("R11 unmapped offset", d, 32'h0);
        rd(8'h50, d, n, s); chk("R11 absent counter", d, 32'h0);
        rd(8'hE4, d, n, s); chk("R11 unused page", d, 32'h0);
        rd(8'h00, d, n, s);
        @(negedge clk); addr = 8'hF4;
        @(negedge clk); chk("R11 data held without strobe", rdata, d);

        // Random runs mixed across counters and modes
        for (int it = 0; it < 16; it++) begin
            int idx;
            logic [31:0] l, b;
            logic [7:0] c;
            idx = int'($urandom_range(0, N - 1));
            l = 32'($urandom_range(1, 300));
            b = 32'($urandom_range(1, 300));
            c = {1'b0, 1'($urandom_range(0, 1)), 2'b00, 2'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), 1'b0};
            for (int i = 0; i < N; i++) wr(8'((i << 4) | 8), 32'h0, x);
            wr(8'hFC, 32'hF, x);
            start_cnt(idx, l, b, c, e);
            run_check("R3 R4 R5 R7 random", idx, l, b, c, e, 6,
                      int'($urandom_range(0, 40)));
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule